// File: doc/BRIEF.md
# Rotate and Bit-Field Operand Unit

This block shapes an operand on its way between a register file or an I/O data byte and the ALU or destination. It works in one of four modes. It can pass the operand through, rotate it right, pull a bit field out of it, or merge the operand into a field of an existing destination byte. In rotate mode, a rotate count sets how many places the operand turns right. In extract mode, a field position and a field length pick the bits, and the field comes out right-justified. In merge mode, the same field selection decides which bits of the destination byte are replaced.

Field positions count from the most significant end: position 0 names the top bit of the byte. A single extracted bit can feed a nonzero test directly, and the unit gives a registered nonzero flag for this use. Every result is registered. A result appears one clock after the operation is presented with its valid strobe.

Top module: `rotfield_unit`

## Requirements
- R1: When `in_valid` is high on a clock edge, `out_valid` is high after that edge and carries the result of that operation; otherwise `out_valid` is low. After reset, `out_valid`, `src_out`, `dst_out` and `src_nz` are all 0.
- R2: The `mode` encoding is 0 = pass, 1 = rotate right, 2 = field extract, 3 = field merge. In pass mode `src_out` equals `src_data` and `dst_out` equals `dst_byte`.
- R3: In rotate mode `src_out` is `src_data` rotated right by `rot_amt` places, taken modulo the data width, so a count of 0 returns the operand unchanged. `dst_out` equals `dst_byte`.
- R4: Field numbering is MSB-first: field bit n is data bit `DATA_W-1-n`. A field at position p with length L covers data bits `DATA_W-1-p` down to `DATA_W-p-L`. In extract mode `src_out` holds that field right-justified, with zeros above it. `dst_out` equals `dst_byte`.
- R5: A field length of 0 is taken as 1, and a length above `DATA_W` is taken as `DATA_W`. If the position plus the effective length exceeds `DATA_W`, the position becomes `DATA_W` minus the length, which pins the field to the low end of the byte.
- R6: In merge mode `dst_out` is `dst_byte` with the selected field replaced by the low L bits of `src_data`. Higher source bits are discarded, and every bit outside the field keeps its value. `src_out` equals `src_data`.
- R7: Position 0 with length `DATA_W` selects the whole byte. Extract then returns `src_data`, and merge returns `src_data` as the destination byte.
- R8: `src_nz` is 1 exactly when the registered `src_out` is nonzero, in the same cycle.
- R9: While `in_valid` is low, `src_out`, `dst_out` and `src_nz` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Operation select (see R2) |
| src_data | input | DATA_W | Source operand |
| dst_byte | input | DATA_W | Existing destination byte for merge |
| rot_amt | input | $clog2(DATA_W) | Rotate-right count |
| fld_pos | input | $clog2(DATA_W) | Field position, MSB-first |
| fld_len | input | $clog2(DATA_W)+1 | Field length |
| out_valid | output | 1 | Result valid |
| src_out | output | DATA_W | Processed source value |
| dst_out | output | DATA_W | Merged destination byte |
| src_nz | output | 1 | `src_out` is nonzero |

## Verification
The bench builds the unit with `DATA_W` = 8 and the log-stage barrel rotator. With an 8-bit width the three-bit count and position fields can be driven to their extremes. It also makes the four-bit length field reach past the width, which exercises both clamps (length 0 and 12, and position 6 with length 4). Rotate counts 0, 4, 5 and 7 each switch on a different mix of barrel stages. The sequence ends with single-bit fields at both ends of the byte, the full-byte field, and idle cycles in which the data inputs change while the strobe is low.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [1:0] {
      RF_PASS     = 2'd0,
      RF_ROTR     = 2'd1,
      RF_FIELD_RD = 2'd2,
      RF_FIELD_WR = 2'd3
   } rf_mode_e;

   localparam int RF_ROT_BARREL = 0;
   localparam int RF_ROT_MUX    = 1;
endpackage

// File: rtl/rf_field_ctl.sv
module rf_field_ctl #(
   parameter int DATA_W = 8,
   localparam int CW = $clog2(DATA_W),
   localparam int LW = CW + 1
) (
   input  logic [CW-1:0]     pos,
   input  logic [LW-1:0]     len,
   output logic [LW-1:0]     shift,
   output logic [DATA_W-1:0] mask
);
   localparam logic [LW-1:0] WX = LW'(DATA_W);

   logic [LW-1:0] len_x;
   logic [LW-1:0] pos_x;
   logic [LW-1:0] sum_x;

   always_comb begin
      if (len == '0)
         len_x = LW'(1);
      else if (len > WX)
         len_x = WX;
      else
         len_x = len;
      sum_x = {1'b0, pos} + len_x;
      if (sum_x > WX)
         pos_x = WX - len_x;
      else
         pos_x = {1'b0, pos};
      shift = WX - pos_x - len_x;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (LW'(i) < len_x);
   end
endmodule

// File: rtl/rf_rotator.sv
module rf_rotator #(
   parameter int DATA_W   = 8,
   parameter int ROT_IMPL = 0,
   localparam int CW = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CW-1:0]     amt,
   output logic [DATA_W-1:0] dout
);
   if (ROT_IMPL == rf_pkg::RF_ROT_BARREL) begin : g_barrel
      logic [DATA_W-1:0] stg [0:CW];
      assign stg[0] = din;
      for (genvar s = 0; s < CW; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]} : stg[s];
      end
      assign dout = stg[CW];
   end else begin : g_mux
      logic [2*DATA_W-1:0] dbl;
      logic [DATA_W-1:0]   cand [0:DATA_W-1];
      assign dbl = {din, din};
      for (genvar k = 0; k < DATA_W; k++) begin : g_cand
         assign cand[k] = dbl[k +: DATA_W];
      end
      assign dout = cand[amt];
   end
endmodule

// File: rtl/rf_field_unit.sv
module rf_field_unit #(
   parameter int DATA_W = 8,
   localparam int CW = $clog2(DATA_W),
   localparam int LW = CW + 1
) (
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic [LW-1:0]     shift,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] extracted,
   output logic [DATA_W-1:0] merged
);
   logic [DATA_W-1:0] place_mask;
   logic [DATA_W-1:0] place_val;

   assign extracted  = (src >> shift) & mask;
   assign place_mask = mask << shift;
   assign place_val  = (src & mask) << shift;
   assign merged     = (dst & ~place_mask) | place_val;
endmodule

// File: rtl/rotfield_unit.sv
module rotfield_unit
   import rf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ROT_IMPL = RF_ROT_BARREL,
   localparam int CW = $clog2(DATA_W),
   localparam int LW = CW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] src_data,
   input  logic [DATA_W-1:0] dst_byte,
   input  logic [CW-1:0]     rot_amt,
   input  logic [CW-1:0]     fld_pos,
   input  logic [LW-1:0]     fld_len,
   output logic              out_valid,
   output logic [DATA_W-1:0] src_out,
   output logic [DATA_W-1:0] dst_out,
   output logic              src_nz
);
   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("rotfield_unit: DATA_W must be a power of two of at least 2");
   end
   if (ROT_IMPL != RF_ROT_BARREL && ROT_IMPL != RF_ROT_MUX) begin : g_bad_impl
      $error("rotfield_unit: ROT_IMPL selects an unknown rotator");
   end

   rf_mode_e          op;
   logic [LW-1:0]     f_shift;
   logic [DATA_W-1:0] f_mask;
   logic [DATA_W-1:0] rot_val;
   logic [DATA_W-1:0] ext_val;
   logic [DATA_W-1:0] mrg_val;
   logic [DATA_W-1:0] src_d;
   logic [DATA_W-1:0] dst_d;

   assign op = rf_mode_e'(mode);

   rf_field_ctl #(.DATA_W(DATA_W)) u_ctl (
      .pos   (fld_pos),
      .len   (fld_len),
      .shift (f_shift),
      .mask  (f_mask)
   );

   rf_rotator #(.DATA_W(DATA_W), .ROT_IMPL(ROT_IMPL)) u_rot (
      .din  (src_data),
      .amt  (rot_amt),
      .dout (rot_val)
   );

   rf_field_unit #(.DATA_W(DATA_W)) u_fld (
      .src       (src_data),
      .dst       (dst_byte),
      .shift     (f_shift),
      .mask      (f_mask),
      .extracted (ext_val),
      .merged    (mrg_val)
   );

   always_comb begin
      src_d = src_data;
      dst_d = dst_byte;
      case (op)
         RF_ROTR:     src_d = rot_val;
         RF_FIELD_RD: src_d = ext_val;
         RF_FIELD_WR: dst_d = mrg_val;
         default:     ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         src_out   <= '0;
         dst_out   <= '0;
         src_nz    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            src_out <= src_d;
            dst_out <= dst_d;
            src_nz  <= |src_d;
         end
      end
   end
endmodule

// File: rtl/rotfield_unit_chk.sv
module rotfield_unit_chk
   import rf_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CW = $clog2(DATA_W),
   localparam int LW = CW + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        mode,
   input logic [DATA_W-1:0] src_data,
   input logic [DATA_W-1:0] dst_byte,
   input logic [CW-1:0]     rot_amt,
   input logic [CW-1:0]     fld_pos,
   input logic [LW-1:0]     fld_len,
   input logic              out_valid,
   input logic [DATA_W-1:0] src_out,
   input logic [DATA_W-1:0] dst_out,
   input logic              src_nz
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == RF_PASS) |=> (src_out == $past(src_data) && dst_out == $past(dst_byte))); // R2
   AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == RF_ROTR) |=> ($countones(src_out) == $countones($past(src_data)))); // R3
   AST_BIT_RIGHT_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == RF_FIELD_RD && fld_len <= LW'(1)) |=> (src_out[DATA_W-1:1] == '0)); // R4
   AST_MERGE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == RF_FIELD_WR && fld_len != '0 && fld_len <= LW'(DATA_W))
      |=> ($countones(dst_out ^ $past(dst_byte)) <= int'($past(fld_len)))); // R6
   AST_NZ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (src_nz == (src_out != '0))); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(src_out) && $stable(dst_out) && $stable(src_nz))); // R9
endmodule

bind rotfield_unit rotfield_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .mode      (mode),
   .src_data  (src_data),
   .dst_byte  (dst_byte),
   .rot_amt   (rot_amt),
   .fld_pos   (fld_pos),
   .fld_len   (fld_len),
   .out_valid (out_valid),
   .src_out   (src_out),
   .dst_out   (dst_out),
   .src_nz    (src_nz)
);

// File: tb/sim_rotfield_unit.sv
`timescale 1ns/1ps
module sim_rotfield_unit;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] s;
      logic [W-1:0] d;
      logic         nz;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] src_data = '0;
   logic [W-1:0] dst_byte = '0;
   logic [2:0]   rot_amt = '0;
   logic [2:0]   fld_pos = '0;
   logic [3:0]   fld_len = '0;
   logic         out_valid;
   logic [W-1:0] src_out;
   logic [W-1:0] dst_out;
   logic         src_nz;

   int checks = 0;
   int fails = 0;
   exp_t sb[$];
   logic [W-1:0] last_s = '0;
   logic [W-1:0] last_d = '0;
   logic         last_nz = 1'b0;

   always #2.5 clk = ~clk;

   rotfield_unit #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .src_data(src_data), .dst_byte(dst_byte), .rot_amt(rot_amt),
      .fld_pos(fld_pos), .fld_len(fld_len), .out_valid(out_valid),
      .src_out(src_out), .dst_out(dst_out), .src_nz(src_nz)
   );

   function automatic void model(input logic [1:0] m, input logic [W-1:0] s, input logic [W-1:0] d,
                                 input int r, input int p, input int l,
                                 output logic [W-1:0] os, output logic [W-1:0] od);
      int ll;
      int pp;
      ll = (l == 0) ? 1 : ((l > W) ? W : l);
      pp = (p + ll > W) ? W - ll : p;
      os = s;
      od = d;
      case (m)
         2'd1: for (int i = 0; i < W; i++) os[i] = s[(i + r) % W];
         2'd2: begin
            os = '0;
            for (int k = 0; k < ll; k++) os[ll-1-k] = s[W-1-pp-k];
         end
         2'd3: for (int k = 0; k < ll; k++) od[W-1-pp-k] = s[ll-1-k];
         default: ;
      endcase
   endfunction

   task automatic send(input logic [1:0] m, input logic [W-1:0] s, input logic [W-1:0] d,
                       input int r, input int p, input int l, input string tag);
      exp_t e;
      @(negedge clk);
      mode = m; src_data = s; dst_byte = d;
      rot_amt = 3'(r); fld_pos = 3'(p); fld_len = 4'(l);
      in_valid = 1'b1;
      model(m, s, d, r, p, l, e.s, e.d);
      e.nz = (e.s != '0);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R1", "result without request", src_out, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(src_out == e.s, e.tag, "src_out", src_out, e.s);
            check(dst_out == e.d, e.tag, "dst_out", dst_out, e.d);
            check(src_nz == e.nz, "R8", "src_nz", W'(src_nz), W'(e.nz));
            last_s = e.s; last_d = e.d; last_nz = e.nz;
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && src_out == '0 && dst_out == '0 && src_nz == 1'b0,
            "R1", "reset state", src_out, '0);
      rst_n = 1'b1;
      idle(2);
      check(out_valid == 1'b0, "R1", "valid idle", W'(out_valid), '0);

      send(2'd0, 8'hA5, 8'h3C, 3, 2, 4, "R2");
      send(2'd1, 8'h81, 8'h11, 5, 0, 0, "R3");
      send(2'd1, 8'h6B, 8'h22, 0, 0, 0, "R3");
      send(2'd1, 8'hF0, 8'h00, 4, 0, 0, "R3");
      send(2'd1, 8'h01, 8'h00, 7, 0, 0, "R3");
      send(2'd2, 8'h80, 8'h55, 0, 0, 1, "R4");
      send(2'd2, 8'h01, 8'h55, 0, 7, 1, "R4");
      send(2'd2, 8'hDF, 8'h55, 0, 2, 1, "R4");
      send(2'd2, 8'hDB, 8'h00, 0, 2, 1, "R8");
      send(2'd2, 8'h38, 8'h00, 0, 2, 3, "R4");
      send(2'd2, 8'hC3, 8'h00, 0, 6, 2, "R4");
      idle(1);
      send(2'd2, 8'h40, 8'h00, 0, 1, 0, "R5");
      send(2'd2, 8'h96, 8'h00, 0, 3, 12, "R5");
      send(2'd2, 8'h2D, 8'h00, 0, 6, 4, "R5");
      send(2'd3, 8'hFF, 8'h00, 0, 7, 5, "R5");
      send(2'd3, 8'h06, 8'h00, 0, 4, 3, "R6");
      send(2'd3, 8'hFF, 8'h00, 0, 1, 2, "R6");
      send(2'd3, 8'h01, 8'hF7, 0, 4, 1, "R6");
      send(2'd3, 8'h0A, 8'hFF, 0, 0, 3, "R6");
      send(2'd2, 8'h5A, 8'h00, 0, 0, 8, "R7");
      send(2'd3, 8'hC6, 8'h39, 0, 0, 8, "R7");
      idle(1);

      @(negedge clk);
      mode = 2'd1; src_data = 8'h00; dst_byte = 8'hEE; rot_amt = 3'd3;
      repeat (3) @(negedge clk);
      check(src_out == last_s, "R9", "src_out held", src_out, last_s);
      check(dst_out == last_d, "R9", "dst_out held", dst_out, last_d);
      check(src_nz == last_nz, "R9", "src_nz held", W'(src_nz), W'(last_nz));
      check(out_valid == 1'b0, "R1", "valid low when idle", W'(out_valid), '0);
      check(sb.size() == 0, "R1", "results outstanding", W'(sb.size()), '0);
      finish_run();
   end
endmodule